// File: doc/BRIEF.md
# Phase-Programmable PWM Edge Generator

This block drives one PWM output whose rising edge and falling edge each sit at a chosen position inside a fixed frame. Most PWM outputs always start their pulse at counter overflow, so only the width can be set. Here both the start and the end are programmable, which sets the phase of the pulse as well as its width. A free-running prescaler makes one tick every 2^DIV_W input clocks (256 by default). An 8-bit frame counter advances once per tick and wraps freely, so a frame is 256 ticks long. At 8 MHz a tick lasts 32 us and a frame lasts 8.192 ms, about 122 Hz.

The output goes high on the tick where the counter reaches the rise position and low on the tick where it reaches the fall position. Between those ticks it keeps its value. A frame-sync output is high for one tick period from the moment the counter wraps to zero. A scope can trigger on it to see where the pulse sits in the frame. New positions are captured on a load strobe. They take effect only from the next frame start, so a frame in progress never gets a glitched or missing edge.

Top module: `pwm_phase_gen`

## Requirements
- R1: After reset, pwm_out and frame_sync are 0, the prescaler and frame counter are 0, and the positions in force are rise 0x32 and fall 0x64. pwm_out stays 0 while run_en has not been raised.
- R2: While run_en is high, one tick occurs every 2^DIV_W clocks. The frame counter rises by one per tick and wraps from 0xFF to 0x00. The counter reaches value n on the clock edge that is n*2^DIV_W enabled clocks after reset.
- R3: pwm_out goes to 1 on the clock edge of the tick at which the frame counter becomes the rise position. With the reset defaults this is tick 0x32.
- R4: pwm_out goes to 0 on the tick at which the frame counter becomes the fall position. With the reset defaults this is tick 0x64, so the output is high for 50 of 256 ticks.
- R5: When the rise and fall positions are equal, the rise wins. pwm_out is set to 1 at that count and no falling edge occurs.
- R6: Between matching ticks, pwm_out keeps its last value. If the fall position is lower than the rise position, the high interval runs across the frame wrap.
- R7: frame_sync is 1 for exactly one tick period. It starts on the tick at which the frame counter becomes 0x00 and is 0 at all other times.
- R8: A clock with pos_load high captures rise_pos and fall_pos. The positions in force for the current frame are unchanged, and the captured values apply from the next wrap to 0x00.
- R9: While run_en is low, the prescaler and frame counter hold their values. pwm_out and frame_sync hold, and no edge or sync pulse is produced. Counting resumes from the held state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Enables the prescaler and frame counter |
| pos_load | input | 1 | Captures rise_pos and fall_pos for the next frame |
| rise_pos | input | CNT_W | Frame count at which the output goes high |
| fall_pos | input | CNT_W | Frame count at which the output goes low |
| pwm_out | output | 1 | PWM output |
| frame_sync | output | 1 | High for one tick from each frame start |

## Verification
The bench targets the exact clock of each edge. An edge that is off by one tick, or that compares against the old count instead of the new one, is caught one clock early or late. A load in the middle of a frame must leave the current falling edge alone. A design that applies new positions at once would drop the pulse early and fail that check. Equal positions check that set has priority: a design with the comparisons in the wrong order would never go high. A fall position below the rise position checks that the high interval runs across the frame wrap. A pause of run_en checks that a design which keeps its prescaler running is caught, because its edge would arrive early.

// File: rtl/pwm_phase_pkg.sv
package pwm_phase_pkg;
  localparam int unsigned FRAME_W_DEF = 8;
  localparam int unsigned DIV_W_DEF   = 8;
  localparam logic [7:0]  RISE_DEF    = 8'h32;
  localparam logic [7:0]  FALL_DEF    = 8'h64;

  typedef enum logic [1:0] {
    EDGE_HOLD = 2'd0,
    EDGE_SET  = 2'd1,
    EDGE_CLR  = 2'd2
  } edge_act_t;
endpackage

// File: rtl/pwm_tick_div.sv
module pwm_tick_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run_en,
  output logic tick
);
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else if (run_en) div_q <= div_q + 1'b1;
  end

  assign tick = run_en && (div_q == {DIV_W{1'b1}});
endmodule

// File: rtl/pwm_frame_ctr.sv
module pwm_frame_ctr #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             wrap
);
  assign cnt_nxt = cnt_q + 1'b1;
  assign wrap    = tick && (cnt_q == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (tick) cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/pwm_pos_shadow.sv
module pwm_pos_shadow #(
  parameter int unsigned     CNT_W     = 8,
  parameter logic [CNT_W-1:0] RISE_INIT = 8'h32,
  parameter logic [CNT_W-1:0] FALL_INIT = 8'h64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] rise_in,
  input  logic [CNT_W-1:0] fall_in,
  input  logic             wrap,
  output logic [CNT_W-1:0] rise_act,
  output logic [CNT_W-1:0] fall_act,
  output logic [CNT_W-1:0] rise_eff,
  output logic [CNT_W-1:0] fall_eff
);
  logic [CNT_W-1:0] rise_sh, fall_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_sh <= RISE_INIT;
      fall_sh <= FALL_INIT;
    end else if (load) begin
      rise_sh <= rise_in;
      fall_sh <= fall_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_act <= RISE_INIT;
      fall_act <= FALL_INIT;
    end else if (wrap) begin
      rise_act <= rise_sh;
      fall_act <= fall_sh;
    end
  end

  // The compare at the wrap tick belongs to the frame that is starting.
  assign rise_eff = wrap ? rise_sh : rise_act;
  assign fall_eff = wrap ? fall_sh : fall_act;
endmodule

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen
  import pwm_phase_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] rise_eff,
  input  logic [CNT_W-1:0] fall_eff,
  output logic             pwm_q,
  output logic             sync_q
);
  edge_act_t act;

  always_comb begin
    act = EDGE_HOLD;
    if (tick) begin
      if (cnt_nxt == rise_eff)      act = EDGE_SET;
      else if (cnt_nxt == fall_eff) act = EDGE_CLR;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else begin
      case (act)
        EDGE_SET: pwm_q <= 1'b1;
        EDGE_CLR: pwm_q <= 1'b0;
        default:  pwm_q <= pwm_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 1'b0;
    else if (tick) sync_q <= (cnt_nxt == '0);
  end
endmodule

// File: rtl/pwm_phase_gen.sv
module pwm_phase_gen
  import pwm_phase_pkg::*;
#(
  parameter int unsigned      DIV_W     = DIV_W_DEF,
  parameter int unsigned      CNT_W     = FRAME_W_DEF,
  parameter logic [CNT_W-1:0] RISE_INIT = RISE_DEF,
  parameter logic [CNT_W-1:0] FALL_INIT = FALL_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic             pos_load,
  input  logic [CNT_W-1:0] rise_pos,
  input  logic [CNT_W-1:0] fall_pos,
  output logic             pwm_out,
  output logic             frame_sync
);
  logic             tick;
  logic             wrap;
  logic [CNT_W-1:0] frame_cnt, cnt_nxt;
  logic [CNT_W-1:0] rise_act, fall_act, rise_eff, fall_eff;

  pwm_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run_en(run_en), .tick(tick)
  );

  pwm_frame_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst(rst), .tick(tick),
    .cnt_q(frame_cnt), .cnt_nxt(cnt_nxt), .wrap(wrap)
  );

  pwm_pos_shadow #(.CNT_W(CNT_W), .RISE_INIT(RISE_INIT), .FALL_INIT(FALL_INIT)) u_pos (
    .clk(clk), .rst(rst), .load(pos_load),
    .rise_in(rise_pos), .fall_in(fall_pos), .wrap(wrap),
    .rise_act(rise_act), .fall_act(fall_act),
    .rise_eff(rise_eff), .fall_eff(fall_eff)
  );

  pwm_edge_gen #(.CNT_W(CNT_W)) u_edge (
    .clk(clk), .rst(rst), .tick(tick), .cnt_nxt(cnt_nxt),
    .rise_eff(rise_eff), .fall_eff(fall_eff),
    .pwm_q(pwm_out), .sync_q(frame_sync)
  );
endmodule

// File: rtl/pwm_phase_chk.sv
module pwm_phase_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             run_en,
  input logic             tick,
  input logic [CNT_W-1:0] frame_cnt,
  input logic [CNT_W-1:0] rise_act,
  input logic [CNT_W-1:0] fall_act,
  input logic             pwm_out,
  input logic             frame_sync
);
  assert_out_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> ($stable(pwm_out) && $stable(frame_sync)));

  assert_cnt_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> $stable(frame_cnt));

  assert_edge_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(pwm_out) |-> $past(tick));

  assert_rise_pos_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm_out) |-> (frame_cnt == rise_act));

  assert_fall_pos_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(pwm_out) |-> (frame_cnt == fall_act));

  assert_no_fall_equal_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(pwm_out) |-> (rise_act != fall_act));

  assert_sync_at_zero_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_sync) |-> (frame_cnt == '0));

  assert_sync_width_R7: assert property (@(posedge clk) disable iff (rst)
    (frame_sync && tick) |=> !frame_sync);
endmodule

bind pwm_phase_gen pwm_phase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .run_en(run_en), .tick(tick),
  .frame_cnt(frame_cnt), .rise_act(rise_act), .fall_act(fall_act),
  .pwm_out(pwm_out), .frame_sync(frame_sync)
);

// File: tb/sim_pwm_phase_gen.sv
module sim_pwm_phase_gen;
  localparam int CLK_P = 10;
  localparam int DIV_W = 2;
  localparam int TPD   = 1 << DIV_W;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run_en = 1'b0;
  logic       pos_load = 1'b0;
  logic [7:0] rise_pos = '0;
  logic [7:0] fall_pos = '0;
  logic       pwm_out, frame_sync;

  int n_chk  = 0;
  int n_fail = 0;
  int now    = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pwm_phase_gen #(.DIV_W(DIV_W)) u0 (
    .clk(clk), .rst(rst), .run_en(run_en), .pos_load(pos_load),
    .rise_pos(rise_pos), .fall_pos(fall_pos),
    .pwm_out(pwm_out), .frame_sync(frame_sync)
  );

  function automatic int tk(input int t);
    return t * TPD;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b (enabled clocks %0d)", req, what, act, exp, now);
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (run_en) now++;
    #(CLK_P/4);
  endtask

  task automatic go_to(input int target);
    while (now < target) step();
  endtask

  task automatic do_reset();
    rst = 1'b1; run_en = 1'b0; pos_load = 1'b0;
    repeat (3) step();
    rst = 1'b0;
    now = 0;
    run_en = 1'b1;
  endtask

  task automatic load_pos(input logic [7:0] r, input logic [7:0] f);
    rise_pos = r; fall_pos = f; pos_load = 1'b1;
    step();
    pos_load = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; run_en = 1'b0;
    repeat (3) step();
    rst = 1'b0;
    chk("R1", pwm_out, 1'b0, "pwm after reset");
    chk("R1", frame_sync, 1'b0, "sync after reset");
    repeat (300) step();
    chk("R1", pwm_out, 1'b0, "pwm stays low without enable");
    chk("R9", frame_sync, 1'b0, "no sync without enable");
  endtask

  task automatic t_default();
    do_reset();
    go_to(tk(50) - 1); chk("R3", pwm_out, 1'b0, "before default rise");
    go_to(tk(50));     chk("R3", pwm_out, 1'b1, "default rise at 0x32");
    go_to(tk(100) - 1); chk("R6", pwm_out, 1'b1, "held high before fall");
    go_to(tk(100));    chk("R4", pwm_out, 1'b0, "default fall at 0x64");
  endtask

  task automatic t_sync();
    do_reset();
    go_to(tk(256) - 1); chk("R7", frame_sync, 1'b0, "sync before wrap");
    go_to(tk(256));     chk("R7", frame_sync, 1'b1, "sync at wrap");
    chk("R2", pwm_out, 1'b0, "pwm low at wrap");
    go_to(tk(257) - 1); chk("R7", frame_sync, 1'b1, "sync held one tick");
    go_to(tk(257));     chk("R7", frame_sync, 1'b0, "sync cleared next tick");
  endtask

  task automatic t_reload();
    do_reset();
    go_to(tk(60));
    load_pos(8'h10, 8'h20);
    go_to(tk(100) - 1); chk("R8", pwm_out, 1'b1, "current frame unchanged");
    go_to(tk(100));     chk("R8", pwm_out, 1'b0, "old fall still applies");
    go_to(tk(272) - 1); chk("R8", pwm_out, 1'b0, "before new rise");
    go_to(tk(272));     chk("R8", pwm_out, 1'b1, "new rise at 0x10");
    go_to(tk(288) - 1); chk("R8", pwm_out, 1'b1, "before new fall");
    go_to(tk(288));     chk("R8", pwm_out, 1'b0, "new fall at 0x20");
  endtask

  task automatic t_equal();
    do_reset();
    load_pos(8'h40, 8'h40);
    go_to(tk(320) - 1); chk("R5", pwm_out, 1'b0, "low before equal pos");
    go_to(tk(320));     chk("R5", pwm_out, 1'b1, "set wins on equal");
    go_to(tk(575));     chk("R5", pwm_out, 1'b1, "no fall on equal");
  endtask

  task automatic t_wrap();
    do_reset();
    load_pos(8'hF0, 8'h10);
    go_to(tk(496) - 1); chk("R6", pwm_out, 1'b0, "low before late rise");
    go_to(tk(496));     chk("R6", pwm_out, 1'b1, "rise at 0xF0");
    go_to(tk(512) + 1); chk("R6", pwm_out, 1'b1, "high across wrap");
    chk("R7", frame_sync, 1'b1, "sync during wrapped pulse");
    go_to(tk(528) - 1); chk("R6", pwm_out, 1'b1, "high before early fall");
    go_to(tk(528));     chk("R6", pwm_out, 1'b0, "fall at 0x10");
  endtask

  task automatic t_enable();
    do_reset();
    go_to(tk(60));
    run_en = 1'b0;
    repeat (40) step();
    chk("R9", pwm_out, 1'b1, "pwm held while paused");
    chk("R9", frame_sync, 1'b0, "no sync while paused");
    run_en = 1'b1;
    go_to(tk(100) - 1); chk("R9", pwm_out, 1'b1, "counting resumed from held state");
    go_to(tk(100));     chk("R2", pwm_out, 1'b0, "fall after pause at enabled count");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_default();
    t_sync();
    t_reload();
    t_equal();
    t_wrap();
    t_enable();
    finish_run();
  end
endmodule